// File: doc/BRIEF.md
# Oscilloscope Seven-Segment Digit Renderer

This block paints a row of decimal digits on one oscilloscope channel. Time on the screen is a sweep of one millisecond, cut into numbered timeslots of one microsecond each. An outside counter supplies the current timeslot number and a frame number. The block works out which digit column and which part of that column the slot falls in. It then emits a 2-bit level code, and an external resistor ladder turns that code into a voltage. Level 0 is parked below the visible screen. Levels 1, 2 and 3 are the bottom, middle and top rows of a segment.

Each column is 100 slots wide: a left vertical strip, a horizontal span and a right vertical strip. A horizontal bar is one flat level across the whole span. When a digit lights more than one horizontal bar, the bars take turns from frame to frame. A vertical stroke switches between two levels on every slot, so the beam paints a thick line. The stroke covers the upper half, the lower half or the full height, depending on which segments are lit. The sweep-start pulse is passed through, aligned with the level code, to drive the scope's external trigger.

Top module: `scope_digit_renderer`

## Requirements
- R1: While reset is asserted, `level_o` is 0 and `trig_o` is 0.
- R2: Both outputs are registered with one cycle of latency: `level_o` reflects the slot, frame and digit inputs of the previous clock cycle, and `trig_o` equals `ms_pulse_i` of the previous cycle.
- R3: Slots below START_SLOT (default 100) or at or above START_SLOT + NUM_DIGITS*COL_W (default 700) give level 0. Digit d occupies slots START_SLOT + d*100 to START_SLOT + d*100 + 99, and its BCD value is `digits_i[4d+3:4d]`.
- R4: Column offsets 20 to 79 form the horizontal span. When exactly one horizontal bar is lit, the span shows that bar's level in every frame: top=3, middle=2, bottom=1. When none is lit, the span shows 0.
- R5: When top, middle and bottom bars are all lit, the span shows the bar at position (frame mod 3) in the order top, middle, bottom. Frames 0, 1, 2, 3 give levels 3, 2, 1, 3.
- R6: When exactly two horizontal bars are lit, the span shows the upper lit bar in even frames and the lower lit bar in odd frames.
- R7: In a vertical strip (offsets 0 to 19 use the upper-left and lower-left segments, offsets 80 to 99 use the upper-right and lower-right segments), a stroke with both halves lit gives level 1 on even slots and level 3 on odd slots.
- R8: An upper-half-only stroke gives 2 on even slots and 3 on odd slots. A lower-half-only stroke gives 1 on even slots and 2 on odd slots.
- R9: A vertical strip with neither segment lit gives level 0.
- R10: A BCD value from 10 to 15 blanks its whole column to level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| slot_i | input | SLOT_W (10) | Current timeslot number within the sweep |
| frame_i | input | FRAME_W (2) | Frame number used to pick among lit horizontal bars |
| ms_pulse_i | input | 1 | Sweep-start pulse |
| digits_i | input | 4*NUM_DIGITS (24) | Packed BCD digits; digit 0 is the leftmost column |
| level_o | output | 2 | Registered level code for the resistor ladder |
| trig_o | output | 1 | Registered sweep-start pulse for the external trigger |

## Verification
The bench walks every slot number, including the values above the sweep end, under all four frame values and two digit sets. This covers every digit 0 to 9 and two invalid codes. If the interleave index were wrong, digits 8, 0, 2, 3, 5, 6 and 9 would show the wrong bar in some frame, and frame 3 would land on the bottom bar instead of wrapping to the top. A swapped stroke phase or half mapping shows up as a wrong level on odd or even slots in the vertical strips. An off-by-one in a column edge leaks level 0 into a bar, or a bar into the blank gap. Sweep-start pulses are placed both at slot 0 and in the middle of the sweep, which exposes any misaligned trigger delay.

// File: rtl/scope_seg_pkg.sv
package scope_seg_pkg;

   localparam int BCD_W = 4;
   localparam int LVL_W = 2;

   typedef logic [LVL_W-1:0] level_t;

   localparam level_t LVL_BLANK  = 2'd0;
   localparam level_t LVL_BOTTOM = 2'd1;
   localparam level_t LVL_MIDDLE = 2'd2;
   localparam level_t LVL_TOP    = 2'd3;

   typedef enum logic [1:0] {
      REG_NONE  = 2'd0,
      REG_LEFT  = 2'd1,
      REG_HSPAN = 2'd2,
      REG_RIGHT = 2'd3
   } region_e;

   typedef struct packed {
      logic top;
      logic up_right;
      logic lo_right;
      logic bottom;
      logic lo_left;
      logic up_left;
      logic middle;
   } seg7_t;

   function automatic seg7_t bcd_to_seg(input logic [BCD_W-1:0] bcd);
      seg7_t s;
      s = '0;
      unique case (bcd)
         4'd0: s = '{top:1'b1, up_right:1'b1, lo_right:1'b1, bottom:1'b1,
                     lo_left:1'b1, up_left:1'b1, middle:1'b0};
         4'd1: s = '{top:1'b0, up_right:1'b1, lo_right:1'b1, bottom:1'b0,
                     lo_left:1'b0, up_left:1'b0, middle:1'b0};
         4'd2: s = '{top:1'b1, up_right:1'b1, lo_right:1'b0, bottom:1'b1,
                     lo_left:1'b1, up_left:1'b0, middle:1'b1};
         4'd3: s = '{top:1'b1, up_right:1'b1, lo_right:1'b1, bottom:1'b1,
                     lo_left:1'b0, up_left:1'b0, middle:1'b1};
         4'd4: s = '{top:1'b0, up_right:1'b1, lo_right:1'b1, bottom:1'b0,
                     lo_left:1'b0, up_left:1'b1, middle:1'b1};
         4'd5: s = '{top:1'b1, up_right:1'b0, lo_right:1'b1, bottom:1'b1,
                     lo_left:1'b0, up_left:1'b1, middle:1'b1};
         4'd6: s = '{top:1'b1, up_right:1'b0, lo_right:1'b1, bottom:1'b1,
                     lo_left:1'b1, up_left:1'b1, middle:1'b1};
         4'd7: s = '{top:1'b1, up_right:1'b1, lo_right:1'b1, bottom:1'b0,
                     lo_left:1'b0, up_left:1'b0, middle:1'b0};
         4'd8: s = '{top:1'b1, up_right:1'b1, lo_right:1'b1, bottom:1'b1,
                     lo_left:1'b1, up_left:1'b1, middle:1'b1};
         4'd9: s = '{top:1'b1, up_right:1'b1, lo_right:1'b1, bottom:1'b1,
                     lo_left:1'b0, up_left:1'b1, middle:1'b1};
         default: s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/seg7_decoder.sv
module seg7_decoder
   import scope_seg_pkg::*;
(
   input  logic [BCD_W-1:0] bcd_i,
   output seg7_t            seg_o
);

   always_comb begin
      seg_o = bcd_to_seg(bcd_i);
   end

endmodule

// File: rtl/slot_column_locator.sv
module slot_column_locator
   import scope_seg_pkg::*;
#(
   parameter int SLOT_W     = 10,
   parameter int NUM_DIGITS = 6,
   parameter int COL_W      = 100,
   parameter int VERT_W     = 20,
   parameter int START_SLOT = 100
) (
   input  logic [SLOT_W-1:0]           slot_i,
   input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
   output region_e                     region_o,
   output logic [BCD_W-1:0]            bcd_o
);

   localparam int OFF_W = $clog2(COL_W);
   localparam logic [OFF_W-1:0] HSPAN_LO = OFF_W'(VERT_W);
   localparam logic [OFF_W-1:0] HSPAN_HI = OFF_W'(COL_W - VERT_W);

   logic [NUM_DIGITS-1:0] hit;
   logic [OFF_W-1:0]      offs [NUM_DIGITS];

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_col
      localparam logic [SLOT_W-1:0] COL_LO = SLOT_W'(START_SLOT + d*COL_W);
      localparam logic [SLOT_W-1:0] COL_HI = SLOT_W'(START_SLOT + (d+1)*COL_W - 1);
      logic [SLOT_W-1:0] rel;
      assign hit[d]  = (slot_i >= COL_LO) && (slot_i <= COL_HI);
      assign rel     = slot_i - COL_LO;
      assign offs[d] = rel[OFF_W-1:0];
   end

   logic             found;
   logic [OFF_W-1:0] off_sel;

   always_comb begin
      found   = 1'b0;
      off_sel = '0;
      bcd_o   = '0;
      for (int d = 0; d < NUM_DIGITS; d++) begin
         if (hit[d]) begin
            found   = 1'b1;
            off_sel = offs[d];
            bcd_o   = digits_i[d*BCD_W +: BCD_W];
         end
      end
   end

   always_comb begin
      if (!found)                   region_o = REG_NONE;
      else if (off_sel < HSPAN_LO)  region_o = REG_LEFT;
      else if (off_sel < HSPAN_HI)  region_o = REG_HSPAN;
      else                          region_o = REG_RIGHT;
   end

endmodule

// File: rtl/segment_level_picker.sv
module segment_level_picker
   import scope_seg_pkg::*;
#(
   parameter int FRAME_W = 2
) (
   input  region_e             region_i,
   input  seg7_t               seg_i,
   input  logic [FRAME_W-1:0]  frame_i,
   input  logic                odd_slot_i,
   output level_t              level_o
);

   logic   up_lit, lo_lit;
   level_t vert_lvl;

   always_comb begin
      up_lit = 1'b0;
      lo_lit = 1'b0;
      if (region_i == REG_LEFT) begin
         up_lit = seg_i.up_left;
         lo_lit = seg_i.lo_left;
      end else if (region_i == REG_RIGHT) begin
         up_lit = seg_i.up_right;
         lo_lit = seg_i.lo_right;
      end
   end

   always_comb begin
      unique case ({up_lit, lo_lit})
         2'b11:   vert_lvl = odd_slot_i ? LVL_TOP    : LVL_BOTTOM;
         2'b10:   vert_lvl = odd_slot_i ? LVL_TOP    : LVL_MIDDLE;
         2'b01:   vert_lvl = odd_slot_i ? LVL_MIDDLE : LVL_BOTTOM;
         default: vert_lvl = LVL_BLANK;
      endcase
   end

   logic [1:0] bar_cnt;
   logic [1:0] pick;
   logic [1:0] seen;
   level_t     horiz_lvl;

   always_comb begin
      bar_cnt = 2'({1'b0, seg_i.top}) + 2'({1'b0, seg_i.middle}) + 2'({1'b0, seg_i.bottom});
      unique case (bar_cnt)
         2'd3:    pick = 2'(frame_i % FRAME_W'(3));
         2'd2:    pick = {1'b0, frame_i[0]};
         default: pick = 2'd0;
      endcase
   end

   always_comb begin
      horiz_lvl = LVL_BLANK;
      seen      = 2'd0;
      if (seg_i.top) begin
         if (seen == pick) horiz_lvl = LVL_TOP;
         seen = seen + 2'd1;
      end
      if (seg_i.middle) begin
         if (seen == pick) horiz_lvl = LVL_MIDDLE;
         seen = seen + 2'd1;
      end
      if (seg_i.bottom) begin
         if (seen == pick) horiz_lvl = LVL_BOTTOM;
      end
   end

   always_comb begin
      unique case (region_i)
         REG_HSPAN:           level_o = horiz_lvl;
         REG_LEFT, REG_RIGHT: level_o = vert_lvl;
         default:             level_o = LVL_BLANK;
      endcase
   end

endmodule

// File: rtl/scope_digit_renderer.sv
module scope_digit_renderer
   import scope_seg_pkg::*;
#(
   parameter int SLOT_W      = 10,
   parameter int FRAME_W     = 2,
   parameter int NUM_DIGITS  = 6,
   parameter int COL_W       = 100,
   parameter int VERT_W      = 20,
   parameter int START_SLOT  = 100,
   parameter int SWEEP_SLOTS = 1000
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [SLOT_W-1:0]           slot_i,
   input  logic [FRAME_W-1:0]          frame_i,
   input  logic                        ms_pulse_i,
   input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
   output logic [LVL_W-1:0]            level_o,
   output logic                        trig_o
);

   localparam int END_SLOT = START_SLOT + NUM_DIGITS*COL_W;

   if (END_SLOT > SWEEP_SLOTS) begin : g_bad_fit
      $error("digit columns run past the end of the sweep");
   end
   if (SWEEP_SLOTS > (1 << SLOT_W)) begin : g_bad_slot_w
      $error("SLOT_W too narrow for SWEEP_SLOTS");
   end
   if (2*VERT_W >= COL_W) begin : g_bad_vert
      $error("vertical strips leave no horizontal span");
   end
   if (FRAME_W < 2) begin : g_bad_frame
      $error("FRAME_W must cover three frames");
   end
   if (NUM_DIGITS < 1) begin : g_bad_num
      $error("NUM_DIGITS must be at least 1");
   end

   region_e          region;
   logic [BCD_W-1:0] bcd;
   seg7_t            seg;
   level_t           level_d;

   slot_column_locator #(
      .SLOT_W     (SLOT_W),
      .NUM_DIGITS (NUM_DIGITS),
      .COL_W      (COL_W),
      .VERT_W     (VERT_W),
      .START_SLOT (START_SLOT)
   ) u_locate (
      .slot_i   (slot_i),
      .digits_i (digits_i),
      .region_o (region),
      .bcd_o    (bcd)
   );

   seg7_decoder u_dec (
      .bcd_i (bcd),
      .seg_o (seg)
   );

   segment_level_picker #(
      .FRAME_W (FRAME_W)
   ) u_pick (
      .region_i   (region),
      .seg_i      (seg),
      .frame_i    (frame_i),
      .odd_slot_i (slot_i[0]),
      .level_o    (level_d)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         level_o <= LVL_BLANK;
         trig_o  <= 1'b0;
      end else begin
         level_o <= level_d;
         trig_o  <= ms_pulse_i;
      end
   end

endmodule

// File: rtl/scope_digit_renderer_chk.sv
module scope_digit_renderer_chk
   import scope_seg_pkg::*;
#(
   parameter int SLOT_W     = 10,
   parameter int NUM_DIGITS = 6,
   parameter int COL_W      = 100,
   parameter int VERT_W     = 20,
   parameter int START_SLOT = 100
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic [SLOT_W-1:0]           slot_i,
   input logic                        ms_pulse_i,
   input logic [NUM_DIGITS*BCD_W-1:0] digits_i,
   input logic [LVL_W-1:0]            level_o,
   input logic                        trig_o
);

   localparam logic [SLOT_W-1:0] FIRST = SLOT_W'(START_SLOT);
   localparam logic [SLOT_W-1:0] PAST  = SLOT_W'(START_SLOT + NUM_DIGITS*COL_W);

   AST_TRIG_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ms_pulse_i |=> trig_o);  // R2
   AST_TRIG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ms_pulse_i |=> !trig_o);  // R2
   AST_BLANK_BEFORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_i < FIRST) |=> (level_o == 2'd0));  // R3
   AST_BLANK_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_i >= PAST) |=> (level_o == 2'd0));  // R3

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
      localparam logic [SLOT_W-1:0] LO   = SLOT_W'(START_SLOT + d*COL_W);
      localparam logic [SLOT_W-1:0] HI   = SLOT_W'(START_SLOT + (d+1)*COL_W - 1);
      localparam logic [SLOT_W-1:0] H_LO = SLOT_W'(START_SLOT + d*COL_W + VERT_W);
      localparam logic [SLOT_W-1:0] H_HI = SLOT_W'(START_SLOT + (d+1)*COL_W - VERT_W - 1);
      logic [BCD_W-1:0] dv;
      assign dv = digits_i[d*BCD_W +: BCD_W];

      AST_BAD_BCD_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (slot_i >= LO && slot_i <= HI && dv > 4'd9) |=> (level_o == 2'd0));  // R10
      AST_ONE_NO_BAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (slot_i >= H_LO && slot_i <= H_HI && dv == 4'd1) |=> (level_o == 2'd0));  // R4
      AST_EIGHT_BAR_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (slot_i >= H_LO && slot_i <= H_HI && dv == 4'd8) |=> (level_o != 2'd0));  // R5
   end

endmodule

bind scope_digit_renderer scope_digit_renderer_chk #(
   .SLOT_W     (SLOT_W),
   .NUM_DIGITS (NUM_DIGITS),
   .COL_W      (COL_W),
   .VERT_W     (VERT_W),
   .START_SLOT (START_SLOT)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .slot_i     (slot_i),
   .ms_pulse_i (ms_pulse_i),
   .digits_i   (digits_i),
   .level_o    (level_o),
   .trig_o     (trig_o)
);

// File: tb/sim_scope_digit_renderer.sv
module sim_scope_digit_renderer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  slot = '0;
   logic [1:0]  frame = '0;
   logic        ms = 1'b0;
   logic [23:0] digits = '0;
   logic [1:0]  level;
   logic        trig;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scope_digit_renderer u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .slot_i     (slot),
      .frame_i    (frame),
      .ms_pulse_i (ms),
      .digits_i   (digits),
      .level_o    (level),
      .trig_o     (trig)
   );

   // bits: top, up_right, lo_right, bottom, lo_left, up_left, middle
   localparam logic [6:0] SEGS [10] = '{
      7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001, 7'b0110011,
      7'b1011011, 7'b1011111, 7'b1110000, 7'b1111111, 7'b1111011 };

   int    q_lvl  [$];
   int    q_trig [$];
   int    q_slot [$];
   string q_tag  [$];

   function automatic void model(input int s, input int fr, input logic [23:0] dg,
                                 output int lvl, output string tag);
      int col, off, bcd, k, odd;
      int bars [3];
      logic [6:0] sg;
      logic up, lo;
      lvl = 0;
      if (s < 100 || s >= 700) begin tag = "R3"; return; end
      col = (s - 100) / 100;
      off = (s - 100) % 100;
      bcd = int'(dg[col*4 +: 4]);
      if (bcd > 9) begin tag = "R10"; return; end
      sg  = SEGS[bcd];
      odd = s % 2;
      if (off < 20 || off >= 80) begin
         up = (off < 20) ? sg[1] : sg[5];
         lo = (off < 20) ? sg[2] : sg[4];
         if (up && lo)  begin lvl = odd ? 3 : 1; tag = "R7"; end
         else if (up)   begin lvl = odd ? 3 : 2; tag = "R8"; end
         else if (lo)   begin lvl = odd ? 2 : 1; tag = "R8"; end
         else           begin lvl = 0; tag = "R9"; end
      end else begin
         k = 0;
         if (sg[6]) begin bars[k] = 3; k++; end
         if (sg[0]) begin bars[k] = 2; k++; end
         if (sg[3]) begin bars[k] = 1; k++; end
         if (k == 0) begin lvl = 0; tag = "R4"; end
         else begin
            lvl = bars[fr % k];
            tag = (k == 1) ? "R4" : (k == 2) ? "R6" : "R5";
         end
      end
   endfunction

   task automatic drive(input int s, input int fr, input bit pulse);
      int    lvl;
      string tag;
      @(negedge clk);
      slot  = 10'(s);
      frame = 2'(fr);
      ms    = pulse;
      model(s, fr, digits, lvl, tag);
      q_lvl.push_back(lvl);
      q_trig.push_back(int'(pulse));
      q_slot.push_back(s);
      q_tag.push_back(tag);
   endtask

   // monitor: result of inputs driven before an edge appears after it (R2)
   always @(posedge clk) begin
      #1;
      if (q_lvl.size() > 0) begin
         int    e_l, e_t, s;
         string tg;
         e_l = q_lvl.pop_front();
         e_t = q_trig.pop_front();
         s   = q_slot.pop_front();
         tg  = q_tag.pop_front();
         checks++;
         if (int'(level) != e_l) begin
            fails++;
            $display("FAIL %s slot=%0d frame=%0d level actual=%0d expected=%0d",
                     tg, s, frame, level, e_l);
         end
         checks++;
         if (int'(trig) != e_t) begin
            fails++;
            $display("FAIL R2 slot=%0d trig actual=%0d expected=%0d", s, trig, e_t);
         end
      end
   end

   initial begin
      digits = 24'hC41708;
      slot   = 10'd150;
      ms     = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (level != 2'd0 || trig != 1'b0) begin
         fails++;
         $display("FAIL R1 reset level/trig actual=%0d/%0d expected=0/0", level, trig);
      end
      rst_n = 1'b1;
      ms    = 1'b0;
      // set A: digits 8,0,7,1,4,C ; set B: 2,3,5,6,9,F
      for (int set = 0; set < 2; set++) begin
         digits = (set == 0) ? 24'hC41708 : 24'hF96532;
         for (int fr = 0; fr < 4; fr++) begin
            for (int s = 0; s < 1024; s++) begin
               drive(s, fr, (s == 0) || (s == 517));
            end
         end
      end
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (level != 2'd0 || trig != 1'b0) begin
         fails++;
         $display("FAIL R1 re-reset level/trig actual=%0d/%0d expected=0/0", level, trig);
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(CLK_PERIOD * 150000);
            fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule